// File: doc/BRIEF.md
# TLB Access-Rights and Fault Checker

This block judges a single memory access against the attributes of the translation entry that the lookup stage found for it. It receives a hit flag, the kind of access, the current privilege level and the fields of the matching entry. From these it builds the set of permitted access kinds and picks at most one fault code. It does not search the TLB, map addresses or deliver exceptions. It only returns a verdict that the pipeline can act on.

Permissions come from a privilege window bounded by two levels in the entry, filtered by the entry's access type. When protection checking is on, a protection-id comparison can remove write permission. The dirty, break and reference attribute bits then narrow the permissions and may raise a fault, in a fixed priority order. A smaller privilege number means more privilege. The verdict is registered, so it appears one clock after the inputs are presented.

Top module: `tlbchk_top`

## Requirements
- R1: On a miss (hit low), the permission mask is 000 and the block raises a fault. The fault code is 1 (instruction miss) when the access kind is execute and 2 (data miss) otherwise. Access kind is encoded 0 read, 1 write, 2 execute; the value 3 is treated as a read.
- R2: The permission mask has read at bit 0, write at bit 1 and execute at bit 2. The privilege window works as follows:
  - Read is granted when priv <= pl1.
  - Write is granted when priv <= pl2.
  - Execute is granted when pl2 <= priv <= pl1.
- R3: The access type limits the window as follows:
  - Type 0 keeps read only.
  - Type 1 keeps read and write.
  - Type 2 keeps read and execute.
  - Type 3 keeps all three.
  - Types 4 to 7 keep execute only.
- R4: A protection-id match removes write permission. A match requires all of the following: checking is enabled, the entry's access id is nonzero, and some protection register equals {access_id, 1'b1}.
- R5: An access id of zero, or checking disabled, leaves the permissions untouched whatever the protection registers hold. A register whose low bit is 0 never matches.
- R6: An access whose kind is absent from the mask faults with code 3 (execute) or code 4 (read or write). In that case the mask is returned without any dirty, break or reference narrowing.
- R7: With D clear, write permission is removed, and a write faults with code 5.
- R8: With B set, write permission is removed, and a write faults with code 6, which takes precedence over code 5.
- R9: With T set, the mask keeps only execute. A read or write then faults with code 7, which takes precedence over codes 5 and 6. An execute access raises no fault.
- R10: The fault-valid output is high exactly when the fault code is nonzero. All outputs appear one clock after their inputs. Synchronous reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | 1 | Lookup found a matching entry |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| cur_priv | input | PL_W | Current privilege level |
| prot_chk_en | input | 1 | Enables the protection-id check |
| pid_regs | input | NUM_PID*(AID_W+1) | Protection id registers, packed |
| ent_type | input | 3 | Entry access type |
| ent_pl1 | input | PL_W | Entry read/execute upper privilege bound |
| ent_pl2 | input | PL_W | Entry write bound / execute lower bound |
| ent_aid | input | AID_W | Entry access id |
| ent_t | input | 1 | Reference trap bit |
| ent_d | input | 1 | Dirty bit |
| ent_b | input | 1 | Break bit |
| fault_vld | output | 1 | A fault is reported |
| fault_code | output | 3 | Fault code (0 none, 1 to 7 as above) |
| perm | output | 3 | Permission mask {exec, write, read} |

## Verification
The bench builds the block with PL_W=2, NUM_PID=4 and a narrowed AID_W=6. With these values, random access ids and protection registers collide often enough to exercise both matching and near-miss comparisons. The two-bit privilege field lets random stimulus cover every ordering of priv, pl1 and pl2, including empty and inverted windows. Directed cases cover overlapping D, B and T settings to confirm the fault priority, and a protection fault combined with set attribute bits to confirm that no narrowing happens on that path.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

    localparam int FAULT_W = 3;
    localparam int PERM_W  = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE   = 3'd0,
        FLT_IMISS  = 3'd1,
        FLT_DMISS  = 3'd2,
        FLT_IPROT  = 3'd3,
        FLT_DRIGHT = 3'd4,
        FLT_DIRTY  = 3'd5,
        FLT_BREAK  = 3'd6,
        FLT_REF    = 3'd7
    } fault_e;

    // packed: x at bit 2, w at bit 1, r at bit 0
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        fault_e code;
        perm_t  perm;
    } verdict_t;

    function automatic logic kind_is_exec(acc_kind_e k);
        return k == ACC_EXEC;
    endfunction

    function automatic logic kind_is_write(acc_kind_e k);
        return k == ACC_WRITE;
    endfunction

    // bit of the mask that the access needs
    function automatic perm_t kind_need(acc_kind_e k);
        perm_t n;
        n = '0;
        case (k)
            ACC_EXEC:  n.x = 1'b1;
            ACC_WRITE: n.w = 1'b1;
            default:   n.r = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tlbchk_rights.sv
module tlbchk_rights
    import tlbchk_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] priv,
    input  logic [PL_W-1:0] pl1,
    input  logic [PL_W-1:0] pl2,
    input  logic [2:0]      art,
    output perm_t           base
);

    logic may_r;
    logic may_w;
    logic may_x;

    always_comb begin
        may_r = (priv <= pl1);
        may_w = (priv <= pl2);
        may_x = (pl2 <= priv) && (priv <= pl1);
    end

    always_comb begin
        base = '0;
        case (art)
            3'd0: base.r = may_r;
            3'd1: begin
                base.r = may_r;
                base.w = may_w;
            end
            3'd2: begin
                base.r = may_r;
                base.x = may_x;
            end
            3'd3: begin
                base.r = may_r;
                base.w = may_w;
                base.x = may_x;
            end
            default: base.x = may_x;
        endcase
    end

endmodule

// File: rtl/tlbchk_pid.sv
module tlbchk_pid #(
    parameter int AID_W   = 31,
    parameter int NUM_PID = 4,
    localparam int PID_W  = AID_W + 1
) (
    input  logic                            chk_en,
    input  logic [AID_W-1:0]                aid,
    input  logic [NUM_PID-1:0][PID_W-1:0]   pid_regs,
    output logic                            drop_write
);

    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] hit_vec;

    assign key = {aid, 1'b1};

    genvar g;
    generate
        for (g = 0; g < NUM_PID; g++) begin : g_cmp
            assign hit_vec[g] = (pid_regs[g] == key);
        end
    endgenerate

    assign drop_write = chk_en && (aid != '0) && (|hit_vec);

endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault
    import tlbchk_pkg::*;
(
    input  logic      hit,
    input  acc_kind_e kind,
    input  perm_t     granted,
    input  logic      t_bit,
    input  logic      d_bit,
    input  logic      b_bit,
    output verdict_t  verdict
);

    perm_t need;
    logic  is_x;
    logic  is_w;

    always_comb begin
        need = kind_need(kind);
        is_x = kind_is_exec(kind);
        is_w = kind_is_write(kind);
        verdict.code = FLT_NONE;
        verdict.perm = granted;
        if (!hit) begin
            verdict.perm = '0;
            verdict.code = is_x ? FLT_IMISS : FLT_DMISS;
        end else if ((granted & need) == '0) begin
            verdict.code = is_x ? FLT_IPROT : FLT_DRIGHT;
        end else begin
            // lowest priority first; later ones overwrite
            if (!d_bit) begin
                verdict.perm.w = 1'b0;
                if (is_w) verdict.code = FLT_DIRTY;
            end
            if (b_bit) begin
                verdict.perm.w = 1'b0;
                if (is_w) verdict.code = FLT_BREAK;
            end
            if (t_bit) begin
                verdict.perm.r = 1'b0;
                verdict.perm.w = 1'b0;
                if (!is_x) verdict.code = FLT_REF;
            end
        end
    end

endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
    import tlbchk_pkg::*;
#(
    parameter int PL_W    = 2,
    parameter int AID_W   = 31,
    parameter int NUM_PID = 4,
    localparam int PID_W  = AID_W + 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           hit,
    input  logic [1:0]                     acc_kind,
    input  logic [PL_W-1:0]                cur_priv,
    input  logic                           prot_chk_en,
    input  logic [NUM_PID-1:0][PID_W-1:0]  pid_regs,
    input  logic [2:0]                     ent_type,
    input  logic [PL_W-1:0]                ent_pl1,
    input  logic [PL_W-1:0]                ent_pl2,
    input  logic [AID_W-1:0]               ent_aid,
    input  logic                           ent_t,
    input  logic                           ent_d,
    input  logic                           ent_b,
    output logic                           fault_vld,
    output logic [FAULT_W-1:0]             fault_code,
    output logic [PERM_W-1:0]              perm
);

    perm_t    base;
    perm_t    granted;
    logic     drop_w;
    verdict_t verdict;
    verdict_t verdict_q;

    tlbchk_rights #(.PL_W(PL_W)) u_rights (
        .priv (cur_priv),
        .pl1  (ent_pl1),
        .pl2  (ent_pl2),
        .art  (ent_type),
        .base (base)
    );

    tlbchk_pid #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
        .chk_en     (prot_chk_en),
        .aid        (ent_aid),
        .pid_regs   (pid_regs),
        .drop_write (drop_w)
    );

    always_comb begin
        granted = base;
        if (drop_w) granted.w = 1'b0;
    end

    tlbchk_fault u_fault (
        .hit     (hit),
        .kind    (acc_kind_e'(acc_kind)),
        .granted (granted),
        .t_bit   (ent_t),
        .d_bit   (ent_d),
        .b_bit   (ent_b),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '0;
        else     verdict_q <= verdict;
    end

    assign fault_code = verdict_q.code;
    assign fault_vld  = (verdict_q.code != FLT_NONE);
    assign perm       = verdict_q.perm;

    // R1
    miss_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (fault_vld && perm == 3'b000 &&
                  (fault_code == 3'd1 || fault_code == 3'd2)));

    // R3
    gateway_execonly_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && ent_type[2]) |=> (perm[1:0] == 2'b00));

    // R6
    write_needs_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && acc_kind == 2'd1) |=> (fault_vld || perm[1]));

    // R7
    dirty_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !ent_d && acc_kind == 2'd1) |=> (fault_vld && !perm[1]));

    // R8
    break_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && ent_b && acc_kind == 2'd1) |=> (fault_vld && !perm[1]));

    // R9
    ref_read_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && ent_t && acc_kind == 2'd0) |=> fault_vld);

    // R10
    vld_code_chk: assert property (@(posedge clk) disable iff (rst)
        fault_vld == (fault_code != 3'd0));

endmodule

// File: tb/tb_tlbchk_top.sv
`timescale 1ns/1ps
module tb_tlbchk_top;

    localparam int PL_W    = 2;
    localparam int AID_W   = 6;
    localparam int NUM_PID = 4;
    localparam int PID_W   = AID_W + 1;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          hit;
    logic [1:0]                    acc_kind;
    logic [PL_W-1:0]               cur_priv;
    logic                          prot_chk_en;
    logic [NUM_PID-1:0][PID_W-1:0] pid_regs;
    logic [2:0]                    ent_type;
    logic [PL_W-1:0]               ent_pl1;
    logic [PL_W-1:0]               ent_pl2;
    logic [AID_W-1:0]              ent_aid;
    logic                          ent_t;
    logic                          ent_d;
    logic                          ent_b;
    logic                          fault_vld;
    logic [2:0]                    fault_code;
    logic [2:0]                    perm;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    tlbchk_top #(.PL_W(PL_W), .AID_W(AID_W), .NUM_PID(NUM_PID)) dut (
        .clk(clk), .rst(rst), .hit(hit), .acc_kind(acc_kind),
        .cur_priv(cur_priv), .prot_chk_en(prot_chk_en), .pid_regs(pid_regs),
        .ent_type(ent_type), .ent_pl1(ent_pl1), .ent_pl2(ent_pl2),
        .ent_aid(ent_aid), .ent_t(ent_t), .ent_d(ent_d), .ent_b(ent_b),
        .fault_vld(fault_vld), .fault_code(fault_code), .perm(perm)
    );

    // returns {code[2:0], perm[2:0]} from the requirements
    function automatic logic [5:0] model();
        logic r, w, x, is_x, is_w, match;
        logic [2:0] p, need, c;
        is_x = (acc_kind == 2'd2);
        is_w = (acc_kind == 2'd1);
        if (!hit) return {(is_x ? 3'd1 : 3'd2), 3'b000};
        r = cur_priv <= ent_pl1;
        w = cur_priv <= ent_pl2;
        x = (ent_pl2 <= cur_priv) && (cur_priv <= ent_pl1);
        case (ent_type)
            3'd0: p = {1'b0, 1'b0, r};
            3'd1: p = {1'b0, w, r};
            3'd2: p = {x, 1'b0, r};
            3'd3: p = {x, w, r};
            default: p = {x, 2'b00};
        endcase
        match = 1'b0;
        for (int i = 0; i < NUM_PID; i++)
            if (pid_regs[i] == {ent_aid, 1'b1}) match = 1'b1;
        if (prot_chk_en && ent_aid != 0 && match) p[1] = 1'b0;
        need = is_x ? 3'b100 : (is_w ? 3'b010 : 3'b001);
        if ((p & need) == 3'b000) return {(is_x ? 3'd3 : 3'd4), p};
        c = 3'd0;
        if (ent_t) begin
            p = p & 3'b100;
            if (!is_x) c = 3'd7;
        end
        if (ent_b) begin
            p[1] = 1'b0;
            if (is_w && c == 0) c = 3'd6;
        end
        if (!ent_d) begin
            p[1] = 1'b0;
            if (is_w && c == 0) c = 3'd5;
        end
        return {c, p};
    endfunction

    task automatic defaults();
        hit = 1'b1; acc_kind = 2'd0; cur_priv = '0; prot_chk_en = 1'b0;
        pid_regs = '0; ent_type = 3'd3; ent_pl1 = 2'd3; ent_pl2 = 2'd3;
        ent_aid = '0; ent_t = 1'b0; ent_d = 1'b1; ent_b = 1'b0;
    endtask

    // called at a negedge with inputs applied
    task automatic run(string req);
        logic [5:0] e;
        logic [6:0] exp_v, got_v;
        e = model();
        @(posedge clk);
        @(negedge clk);
        exp_v = {(e[5:3] != 0), e};
        got_v = {fault_vld, fault_code, perm};
        n_chk++;
        if (got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got vld=%b code=%0d perm=%b exp vld=%b code=%0d perm=%b",
                     req, got_v[6], got_v[5:3], got_v[2:0],
                     exp_v[6], exp_v[5:3], exp_v[2:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        defaults();
        rst = 1'b1;
        hit = 1'b0; acc_kind = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset
        n_chk++;
        if ({fault_vld, fault_code, perm} !== 7'd0) begin
            n_fail++;
            $display("FAIL R10 reset: got %b exp 0000000", {fault_vld, fault_code, perm});
        end
        rst = 1'b0;

        // R1 misses
        defaults(); hit = 1'b0; acc_kind = 2'd2; run("R1 exec miss");
        defaults(); hit = 1'b0; acc_kind = 2'd1; run("R1 write miss");
        defaults(); hit = 1'b0; acc_kind = 2'd3; run("R1 reserved kind miss");

        // R2 privilege window
        defaults(); ent_pl1 = 2'd1; ent_pl2 = 2'd0; cur_priv = 2'd1; run("R2 mid priv");
        defaults(); ent_pl1 = 2'd1; ent_pl2 = 2'd0; cur_priv = 2'd2; run("R2 outside window");
        defaults(); ent_pl1 = 2'd1; ent_pl2 = 2'd0; cur_priv = 2'd0; acc_kind = 2'd2; run("R2 top priv exec");

        // R3 access types
        defaults(); ent_type = 3'd0; acc_kind = 2'd1; run("R3 type0 write");
        defaults(); ent_type = 3'd1; acc_kind = 2'd1; run("R3 type1 write");
        defaults(); ent_type = 3'd2; ent_pl2 = 2'd0; acc_kind = 2'd2; run("R3 type2 exec");
        defaults(); ent_type = 3'd5; ent_pl2 = 2'd0; run("R3 gateway read");
        defaults(); ent_type = 3'd6; ent_pl2 = 2'd0; acc_kind = 2'd2; run("R3 gateway exec");

        // R4 protection id match
        defaults(); prot_chk_en = 1'b1; ent_aid = 6'd5; pid_regs[2] = {6'd5, 1'b1};
        acc_kind = 2'd1; run("R4 pid match write");
        defaults(); prot_chk_en = 1'b1; ent_aid = 6'd5; pid_regs[3] = {6'd5, 1'b1};
        run("R4 pid match read");

        // R5 no effect cases
        defaults(); prot_chk_en = 1'b1; ent_aid = '0; pid_regs[0] = 7'd1;
        acc_kind = 2'd1; run("R5 public page");
        defaults(); prot_chk_en = 1'b0; ent_aid = 6'd5; pid_regs[1] = {6'd5, 1'b1};
        acc_kind = 2'd1; run("R5 check disabled");
        defaults(); prot_chk_en = 1'b1; ent_aid = 6'd5; pid_regs[1] = {6'd5, 1'b0};
        acc_kind = 2'd1; run("R5 low bit clear");

        // R6 protection faults, no narrowing
        defaults(); ent_type = 3'd1; ent_d = 1'b0; ent_t = 1'b1; ent_b = 1'b1;
        acc_kind = 2'd2; run("R6 exec on data page");
        defaults(); ent_type = 3'd0; ent_d = 1'b0; acc_kind = 2'd1; run("R6 write on ro page");

        // R7 dirty
        defaults(); ent_d = 1'b0; run("R7 dirty read");
        defaults(); ent_d = 1'b0; acc_kind = 2'd1; run("R7 dirty write");

        // R8 break
        defaults(); ent_d = 1'b0; ent_b = 1'b1; acc_kind = 2'd1; run("R8 break over dirty");
        defaults(); ent_b = 1'b1; run("R8 break read");

        // R9 reference
        defaults(); ent_t = 1'b1; ent_b = 1'b1; ent_d = 1'b0; acc_kind = 2'd1; run("R9 ref over all");
        defaults(); ent_t = 1'b1; ent_pl2 = 2'd0; acc_kind = 2'd2; run("R9 exec no fault");
        defaults(); ent_t = 1'b1; run("R9 ref read");

        // R10 back-to-back change
        defaults(); hit = 1'b0; run("R10 miss then hit");
        defaults(); run("R10 hit after miss");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            hit         = ($urandom % 8) != 0;
            acc_kind    = 2'($urandom);
            cur_priv    = PL_W'($urandom);
            prot_chk_en = 1'($urandom);
            ent_type    = 3'($urandom);
            ent_pl1     = PL_W'($urandom);
            ent_pl2     = PL_W'($urandom);
            ent_aid     = (($urandom % 4) == 0) ? '0 : AID_W'($urandom);
            for (int i = 0; i < NUM_PID; i++) pid_regs[i] = PID_W'($urandom);
            if (($urandom % 2) == 0)
                pid_regs[$urandom % NUM_PID] = {ent_aid, 1'($urandom)};
            ent_t = ($urandom % 4) == 0;
            ent_d = ($urandom % 4) != 0;
            ent_b = ($urandom % 4) == 0;
            run("random R1..R9");
        end

        finish_run();
    end

endmodule